// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block decides which trap a small 16-bit core with a segmented address space services next, and then drives the stack frame for that trap. Several kinds of request can be raised at an instruction boundary: processor faults (divide error, unused opcode, escape opcode), software traps (breakpoint, overflow check, and a general software interrupt that names any of the 256 types), a non-maskable line, a maskable external line with its own type byte, and the single-step trap. The block picks one request by a fixed priority and reports its 8-bit type and the physical address of its vector-table slot. It then writes three 16-bit words to the stack and tells the core to clear the interrupt-enable and trap flags.

The return path works in the opposite direction. A return request reads the three words back in reverse order and presents the restored instruction pointer, code segment and flags, together with the new stack pointer. The block reads and writes no memory itself. It places an address and a strobe on its outputs. For a pop, the surrounding logic must return the addressed word on `pop_data` in the same cycle.

Top module: `trap_sequencer`

## Requirements
- R1: During and after a synchronous reset the block is idle: `busy`, `take_valid`, `stk_we`, `stk_re`, `sp_load` and `ret_valid` are 0, and any non-maskable edge seen before reset is forgotten.
- R2: Type numbers are fixed for these sources:
  - divide error: 0
  - single step: 1
  - non-maskable: 2
  - breakpoint: 3
  - overflow check: 4
  - unused opcode: 6
  - escape opcode: 7
  
  The software interrupt uses `soft_type`, and the maskable line uses `intr_type`, both sampled in the accept cycle.
- R3: `vec_addr` is the 20-bit value `sel_type * 4`, with the type in bits 9:2 and zeros elsewhere.
- R4: The overflow-check request starts an entry only when `flag_of` is 1.
- R5: The maskable line is taken only when `flag_if` is 1. `intr_ack` pulses in the first push cycle of such an entry and in no other entry.
- R6: The non-maskable line is latched on a rising edge and is then taken at the next free boundary, whatever `flag_if` holds. A line held high causes exactly one entry per edge.
- R7: The priority order is:
  1. divide error
  2. unused opcode
  3. escape opcode
  4. breakpoint
  5. overflow check
  6. software interrupt
  7. non-maskable
  8. maskable line
  9. single step
- R8: An entry accepted at a clock edge writes on three consecutive cycles:
  - cycle 1: the accepted `cur_flags` to SP-2;
  - cycle 2: `cur_cs` to SP-4;
  - cycle 3: `cur_ip` to SP-6, with `sp_load` high and `sp_out` = SP-6.
  
  SP here is `cur_sp` at acceptance.
- R9: `take_valid`, `clr_if` and `clr_tf` are high together in the first push cycle of every entry, and only then.
- R10: Requests are evaluated only when `boundary` is 1 and the block is idle. Requests raised without a boundary, or while an entry or return is running, start nothing.
- R11: A return request accepted while idle pops on three consecutive cycles:
  - cycle 1: IP from SP;
  - cycle 2: CS from SP+2;
  - cycle 3: FLAGS from SP+4.
  
  In the fourth cycle `ret_valid` is high with those three words, and `sp_load` is high with `sp_out` = SP+6. If a return request and a boundary arrive in the same cycle, the return wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction boundary strobe |
| req_div | input | 1 | Divide error request |
| req_ill | input | 1 | Unused opcode request |
| req_esc | input | 1 | Escape opcode request |
| req_int3 | input | 1 | Breakpoint request |
| req_into | input | 1 | Overflow-check request |
| flag_of | input | 1 | Overflow flag |
| req_soft | input | 1 | Software interrupt request |
| soft_type | input | 8 | Type named by the software interrupt |
| nmi_pin | input | 1 | Non-maskable interrupt line |
| intr_line | input | 1 | Maskable interrupt line |
| intr_type | input | 8 | Type supplied by the external controller |
| flag_if | input | 1 | Interrupt-enable flag |
| flag_tf | input | 1 | Trap (single-step) flag |
| iret_req | input | 1 | Return-from-trap request |
| cur_flags | input | 16 | Current flags word |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Current instruction pointer |
| cur_sp | input | 16 | Current stack pointer |
| pop_data | input | 16 | Word read at `stk_addr` during a pop |
| busy | output | 1 | Entry or return in progress |
| take_valid | output | 1 | First cycle of an entry |
| sel_type | output | 8 | Selected trap type |
| vec_addr | output | 20 | Vector-table address of `sel_type` |
| intr_ack | output | 1 | Maskable line accepted |
| clr_if | output | 1 | Command to clear the interrupt-enable flag |
| clr_tf | output | 1 | Command to clear the trap flag |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 16 | Stack offset for the current access |
| stk_wdata | output | 16 | Word to write |
| sp_load | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | 16 | New stack pointer value |
| ret_valid | output | 1 | Restored state is valid |
| ret_flags | output | 16 | Restored flags |
| ret_cs | output | 16 | Restored code segment |
| ret_ip | output | 16 | Restored instruction pointer |

## Verification
The bench builds the block with its default widths: 8-bit types, 16-bit words and a 20-bit physical address. This puts every one of the 256 types within reach, so software and external type bytes at both ends of the range are covered. Stack pointers near 0x0000 and 0xFFFF wrap during push and pop arithmetic, which exposes modulo errors in the address math. Randomly mixed request sets exercise the arbitration order against an independent priority function in the bench. Directed cases cover the edge latching of the non-maskable line, masking and the boundary/busy gating.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int TYPE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int PADDR_W = 20;
    localparam int SLOT_SH = 2;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int N_FIXED = 5;

    typedef logic [TYPE_W-1:0]  vtype_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [PADDR_W-1:0] paddr_t;

    typedef enum logic [1:0] {
        SRC_EXC  = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_INTR = 2'd2,
        SRC_STEP = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_FL = 3'd1,
        ST_PUSH_CS = 3'd2,
        ST_PUSH_IP = 3'd3,
        ST_POP_IP  = 3'd4,
        ST_POP_CS  = 3'd5,
        ST_POP_FL  = 3'd6,
        ST_RET     = 3'd7
    } st_e;

    typedef struct packed {
        logic   take;
        vtype_t vtype;
        src_e   src;
    } pick_t;

    localparam vtype_t T_STEP = 8'd1;
    localparam vtype_t T_NMI  = 8'd2;

    // fixed-type fault/trap sources, index 0 is highest priority
    function automatic vtype_t fixed_type(input int idx);
        case (idx)
            0:       return 8'd0;
            1:       return 8'd6;
            2:       return 8'd7;
            3:       return 8'd3;
            default: return 8'd4;
        endcase
    endfunction

    function automatic paddr_t slot_addr(input vtype_t t);
        paddr_t a;
        a = '0;
        a[SLOT_SH +: TYPE_W] = t;
        return a;
    endfunction

endpackage

// File: rtl/trap_nmi_latch.sv
module trap_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_pin,
    input  logic taken,
    output logic pending
);
    logic prev_q;
    logic edge_seen;

    assign edge_seen = nmi_pin & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            prev_q <= nmi_pin;
            if (edge_seen)
                pending <= 1'b1;
            else if (taken)
                pending <= 1'b0;
        end
    end

    // R6: a latched edge stays until it is serviced
    assert_nmi_held_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(pending) && !$past(taken)) |-> pending);

    // R6: a level held high does not re-arm after service
    assert_nmi_once_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(taken) && $past(nmi_pin) && nmi_pin && $past(prev_q)) |=> !pending || $past(edge_seen));

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic [N_FIXED-1:0] fixed_req,
    input  logic               soft_req,
    input  vtype_t             soft_type,
    input  logic               nmi_pend,
    input  logic               intr_line,
    input  logic               flag_if,
    input  vtype_t             intr_type,
    input  logic               flag_tf,
    output pick_t              pick
);
    logic   exc_any;
    vtype_t exc_type;

    // lowest index wins: walk from the bottom so later writes override
    always_comb begin
        exc_type = soft_type;
        for (int i = N_FIXED - 1; i >= 0; i--) begin
            if (fixed_req[i])
                exc_type = fixed_type(i);
        end
    end

    assign exc_any = (|fixed_req) | soft_req;

    always_comb begin
        pick = '{take: 1'b0, vtype: '0, src: SRC_EXC};
        if (exc_any)
            pick = '{take: 1'b1, vtype: exc_type, src: SRC_EXC};
        else if (nmi_pend)
            pick = '{take: 1'b1, vtype: T_NMI, src: SRC_NMI};
        else if (intr_line && flag_if)
            pick = '{take: 1'b1, vtype: intr_type, src: SRC_INTR};
        else if (flag_tf)
            pick = '{take: 1'b1, vtype: T_STEP, src: SRC_STEP};
    end

    // R5: the maskable source is never chosen with interrupts disabled
    always_comb begin
        assert_intr_masked_R5: assert (!(pick.take && pick.src == SRC_INTR) || flag_if);
    end

endmodule

// File: rtl/trap_frame_seq.sv
module trap_frame_seq
    import trap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_entry,
    input  pick_t  pick,
    input  logic   start_ret,
    input  word_t  cur_flags,
    input  word_t  cur_cs,
    input  word_t  cur_ip,
    input  word_t  cur_sp,
    input  word_t  pop_data,
    output logic   busy,
    output logic   take_valid,
    output vtype_t sel_type,
    output src_e   sel_src,
    output logic   stk_we,
    output logic   stk_re,
    output word_t  stk_addr,
    output word_t  stk_wdata,
    output logic   sp_load,
    output word_t  sp_out,
    output logic   ret_valid,
    output word_t  ret_flags,
    output word_t  ret_cs,
    output word_t  ret_ip
);
    localparam word_t STEP1 = word_t'(WORD_BYTES);
    localparam word_t STEP2 = word_t'(2 * WORD_BYTES);
    localparam word_t STEP3 = word_t'(3 * WORD_BYTES);

    st_e   state;
    word_t fl_q, cs_q, ip_q, sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sel_type <= '0;
            sel_src  <= SRC_EXC;
            fl_q     <= '0;
            cs_q     <= '0;
            ip_q     <= '0;
            sp_q     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ret) begin
                        state <= ST_POP_IP;
                        sp_q  <= cur_sp;
                    end else if (start_entry) begin
                        state    <= ST_PUSH_FL;
                        sel_type <= pick.vtype;
                        sel_src  <= pick.src;
                        fl_q     <= cur_flags;
                        cs_q     <= cur_cs;
                        ip_q     <= cur_ip;
                        sp_q     <= cur_sp;
                    end
                end
                ST_PUSH_FL: state <= ST_PUSH_CS;
                ST_PUSH_CS: state <= ST_PUSH_IP;
                ST_PUSH_IP: state <= ST_IDLE;
                ST_POP_IP: begin
                    ip_q  <= pop_data;
                    state <= ST_POP_CS;
                end
                ST_POP_CS: begin
                    cs_q  <= pop_data;
                    state <= ST_POP_FL;
                end
                ST_POP_FL: begin
                    fl_q  <= pop_data;
                    state <= ST_RET;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        stk_we    = 1'b0;
        stk_re    = 1'b0;
        stk_addr  = '0;
        stk_wdata = '0;
        sp_load   = 1'b0;
        sp_out    = '0;
        case (state)
            ST_PUSH_FL: begin
                stk_we = 1'b1; stk_addr = sp_q - STEP1; stk_wdata = fl_q;
            end
            ST_PUSH_CS: begin
                stk_we = 1'b1; stk_addr = sp_q - STEP2; stk_wdata = cs_q;
            end
            ST_PUSH_IP: begin
                stk_we = 1'b1; stk_addr = sp_q - STEP3; stk_wdata = ip_q;
                sp_load = 1'b1; sp_out = sp_q - STEP3;
            end
            ST_POP_IP: begin stk_re = 1'b1; stk_addr = sp_q; end
            ST_POP_CS: begin stk_re = 1'b1; stk_addr = sp_q + STEP1; end
            ST_POP_FL: begin stk_re = 1'b1; stk_addr = sp_q + STEP2; end
            ST_RET: begin
                sp_load = 1'b1; sp_out = sp_q + STEP3;
            end
            default: ;
        endcase
    end

    assign busy       = (state != ST_IDLE);
    assign take_valid = (state == ST_PUSH_FL);
    assign ret_valid  = (state == ST_RET);
    assign ret_flags  = fl_q;
    assign ret_cs     = cs_q;
    assign ret_ip     = ip_q;

    // R8: each further push lands one word below the previous one
    assert_push_step_R8: assert property (@(posedge clk) disable iff (rst)
        (stk_we && !sp_load) |=> (stk_we && stk_addr == $past(stk_addr) - STEP1));

    // R11: each further pop reads one word above the previous one
    assert_pop_step_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(stk_re) && stk_re) |-> (stk_addr == $past(stk_addr) + STEP1));

    // R11: restored state follows a read strobe
    assert_ret_after_pop_R11: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> $past(stk_re));

    // R8: stack pointer load ends a write run
    assert_sp_after_push_R8: assert property (@(posedge clk) disable iff (rst)
        (sp_load && stk_we) |-> $past(stk_we));

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        boundary,
    input  logic        req_div,
    input  logic        req_ill,
    input  logic        req_esc,
    input  logic        req_int3,
    input  logic        req_into,
    input  logic        flag_of,
    input  logic        req_soft,
    input  logic [7:0]  soft_type,
    input  logic        nmi_pin,
    input  logic        intr_line,
    input  logic [7:0]  intr_type,
    input  logic        flag_if,
    input  logic        flag_tf,
    input  logic        iret_req,
    input  logic [15:0] cur_flags,
    input  logic [15:0] cur_cs,
    input  logic [15:0] cur_ip,
    input  logic [15:0] cur_sp,
    input  logic [15:0] pop_data,
    output logic        busy,
    output logic        take_valid,
    output logic [7:0]  sel_type,
    output logic [19:0] vec_addr,
    output logic        intr_ack,
    output logic        clr_if,
    output logic        clr_tf,
    output logic        stk_we,
    output logic        stk_re,
    output logic [15:0] stk_addr,
    output logic [15:0] stk_wdata,
    output logic        sp_load,
    output logic [15:0] sp_out,
    output logic        ret_valid,
    output logic [15:0] ret_flags,
    output logic [15:0] ret_cs,
    output logic [15:0] ret_ip
);
    logic [N_FIXED-1:0] fixed_req;
    logic   nmi_pend;
    pick_t  pick;
    logic   start_entry;
    logic   start_ret;
    logic   idle;
    src_e   sel_src;

    // order of this vector is the priority order (bit 0 highest)
    assign fixed_req = {req_into & flag_of, req_int3, req_esc, req_ill, req_div};

    trap_nmi_latch u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_pin (nmi_pin),
        .taken   (start_entry && pick.src == SRC_NMI),
        .pending (nmi_pend)
    );

    trap_arbiter u_arb (
        .fixed_req (fixed_req),
        .soft_req  (req_soft),
        .soft_type (soft_type),
        .nmi_pend  (nmi_pend),
        .intr_line (intr_line),
        .flag_if   (flag_if),
        .intr_type (intr_type),
        .flag_tf   (flag_tf),
        .pick      (pick)
    );

    assign idle        = ~busy;
    assign start_ret   = idle & iret_req;
    assign start_entry = idle & boundary & ~iret_req & pick.take;

    trap_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_entry (start_entry),
        .pick        (pick),
        .start_ret   (start_ret),
        .cur_flags   (cur_flags),
        .cur_cs      (cur_cs),
        .cur_ip      (cur_ip),
        .cur_sp      (cur_sp),
        .pop_data    (pop_data),
        .busy        (busy),
        .take_valid  (take_valid),
        .sel_type    (sel_type),
        .sel_src     (sel_src),
        .stk_we      (stk_we),
        .stk_re      (stk_re),
        .stk_addr    (stk_addr),
        .stk_wdata   (stk_wdata),
        .sp_load     (sp_load),
        .sp_out      (sp_out),
        .ret_valid   (ret_valid),
        .ret_flags   (ret_flags),
        .ret_cs      (ret_cs),
        .ret_ip      (ret_ip)
    );

    assign vec_addr = slot_addr(sel_type);
    assign clr_if   = take_valid;
    assign clr_tf   = take_valid;
    assign intr_ack = take_valid & (sel_src == SRC_INTR);

    // R5: acknowledge only for an entry accepted with interrupts enabled
    assert_ack_enabled_R5: assert property (@(posedge clk) disable iff (rst)
        intr_ack |-> ($past(flag_if) && $past(intr_line)));

    // R10: a new entry starts only from idle at a boundary
    assert_entry_gated_R10: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (!$past(busy) && $past(boundary)));

    // R11: a return beats a simultaneous boundary
    assert_ret_wins_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(iret_req) && !$past(busy)) |-> (stk_re && !take_valid));

    // R4: overflow check alone never enters without the flag
    assert_into_needs_of_R4: assert property (@(posedge clk) disable iff (rst)
        (take_valid && sel_type == 8'd4 && $past(req_into) && !$past(req_soft)
         && !$past(req_div) && !$past(req_ill) && !$past(req_esc) && !$past(req_int3))
        |-> $past(flag_of));

endmodule

// File: tb/trap_sequencer_test.sv
module trap_sequencer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        boundary, req_div, req_ill, req_esc, req_int3, req_into, flag_of;
    logic        req_soft, nmi_pin, intr_line, flag_if, flag_tf, iret_req;
    logic [7:0]  soft_type, intr_type;
    logic [15:0] cur_flags, cur_cs, cur_ip, cur_sp, pop_data;
    logic        busy, take_valid, intr_ack, clr_if, clr_tf, stk_we, stk_re, sp_load, ret_valid;
    logic [7:0]  sel_type;
    logic [19:0] vec_addr;
    logic [15:0] stk_addr, stk_wdata, sp_out, ret_flags, ret_cs, ret_ip;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    // stack memory model: word content derived from its address
    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return a ^ 16'hA5C3;
    endfunction
    assign pop_data = mem_word(stk_addr);

    trap_sequencer uut (.*);

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_reqs();
        boundary = 0; req_div = 0; req_ill = 0; req_esc = 0; req_int3 = 0;
        req_into = 0; req_soft = 0; intr_line = 0; iret_req = 0;
    endtask

    // independent priority model: returns {take, is_intr, type}
    function automatic logic [9:0] expect_pick(input logic nmi_p);
        if (req_div)              return {2'b10, 8'd0};
        if (req_ill)              return {2'b10, 8'd6};
        if (req_esc)              return {2'b10, 8'd7};
        if (req_int3)             return {2'b10, 8'd3};
        if (req_into && flag_of)  return {2'b10, 8'd4};
        if (req_soft)             return {2'b10, soft_type};
        if (nmi_p)                return {2'b10, 8'd2};
        if (intr_line && flag_if) return {2'b11, intr_type};
        if (flag_tf)              return {2'b10, 8'd1};
        return 10'd0;
    endfunction

    // raise a boundary with requests already set, then follow the frame
    task automatic run_boundary(input logic nmi_p, input string tag);
        logic [9:0]  e;
        logic [15:0] sp0;
        e = expect_pick(nmi_p);
        sp0 = cur_sp;
        boundary = 1;
        @(negedge clk);
        clear_reqs();
        if (!e[9]) begin
            chk(!busy && !take_valid, {tag, " R10 no entry"}, busy, 0);
        end else begin
            chk(take_valid && clr_if && clr_tf, {tag, " R9 entry strobes"}, {take_valid, clr_if, clr_tf}, 3'b111);
            chk(sel_type == e[7:0], {tag, " R2/R7 type"}, sel_type, e[7:0]);
            chk(vec_addr == {10'd0, e[7:0], 2'b00}, {tag, " R3 vector"}, vec_addr, {10'd0, e[7:0], 2'b00});
            chk(intr_ack == e[8], {tag, " R5 ack"}, intr_ack, e[8]);
            chk(stk_we && stk_addr == 16'(sp0 - 16'd2) && stk_wdata == cur_flags,
                {tag, " R8 push flags"}, {stk_addr, stk_wdata}, {16'(sp0 - 16'd2), cur_flags});
            @(negedge clk);
            chk(stk_we && !take_valid && !clr_if && stk_addr == 16'(sp0 - 16'd4) && stk_wdata == cur_cs,
                {tag, " R8 push cs"}, {stk_addr, stk_wdata}, {16'(sp0 - 16'd4), cur_cs});
            @(negedge clk);
            chk(stk_we && sp_load && stk_addr == 16'(sp0 - 16'd6) && stk_wdata == cur_ip && sp_out == 16'(sp0 - 16'd6),
                {tag, " R8 push ip"}, {stk_addr, stk_wdata, sp_out}, {16'(sp0 - 16'd6), cur_ip, 16'(sp0 - 16'd6)});
            @(negedge clk);
            chk(!busy && !stk_we, {tag, " R8 frame done"}, busy, 0);
        end
    endtask

    task automatic run_iret(input logic with_boundary, input string tag);
        logic [15:0] sp0;
        sp0 = cur_sp;
        iret_req = 1;
        boundary = with_boundary;
        req_div = with_boundary;
        @(negedge clk);
        clear_reqs();
        chk(stk_re && !take_valid && stk_addr == sp0, {tag, " R11 pop ip"}, stk_addr, sp0);
        @(negedge clk);
        chk(stk_re && stk_addr == 16'(sp0 + 16'd2), {tag, " R11 pop cs"}, stk_addr, 16'(sp0 + 16'd2));
        @(negedge clk);
        chk(stk_re && stk_addr == 16'(sp0 + 16'd4), {tag, " R11 pop flags"}, stk_addr, 16'(sp0 + 16'd4));
        @(negedge clk);
        chk(ret_valid && sp_load && sp_out == 16'(sp0 + 16'd6), {tag, " R11 sp"}, sp_out, 16'(sp0 + 16'd6));
        chk(ret_ip == mem_word(sp0) && ret_cs == mem_word(16'(sp0 + 16'd2)) && ret_flags == mem_word(16'(sp0 + 16'd4)),
            {tag, " R11 restored"}, {ret_ip, ret_cs, ret_flags},
            {mem_word(sp0), mem_word(16'(sp0 + 16'd2)), mem_word(16'(sp0 + 16'd4))});
        @(negedge clk);
        chk(!busy && !ret_valid, {tag, " R11 done"}, busy, 0);
    endtask

    initial begin
        #400000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd24601));
        clear_reqs();
        flag_of = 0; flag_if = 0; flag_tf = 0; nmi_pin = 0;
        soft_type = 8'h21; intr_type = 8'h08;
        cur_flags = 16'hF202; cur_cs = 16'h1234; cur_ip = 16'h5678; cur_sp = 16'h0100;
        rst = 1;
        nmi_pin = 1;
        repeat (3) @(negedge clk);
        nmi_pin = 0;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: idle after reset and no stale non-maskable edge
        chk(!busy && !take_valid && !stk_we && !stk_re && !sp_load && !ret_valid,
            "R1 reset idle", busy, 0);
        run_boundary(1'b0, "R1 no stale nmi");

        // R2: each fixed type alone
        req_div = 1;  run_boundary(0, "R2 div");
        req_ill = 1;  run_boundary(0, "R2 ill");
        req_esc = 1;  run_boundary(0, "R2 esc");
        req_int3 = 1; run_boundary(0, "R2 int3");
        flag_of = 1; req_into = 1; run_boundary(0, "R4 into of=1");
        flag_of = 0; req_into = 1; run_boundary(0, "R4 into of=0");
        soft_type = 8'hFF; req_soft = 1; run_boundary(0, "R2 soft ff");
        soft_type = 8'h00; req_soft = 1; run_boundary(0, "R2 soft 00");
        flag_tf = 1; run_boundary(0, "R2 step");
        flag_tf = 0;

        // R5: masking of the external line
        intr_line = 1; flag_if = 0; run_boundary(0, "R5 masked");
        intr_line = 1; flag_if = 1; intr_type = 8'hC4; run_boundary(0, "R5 enabled");

        // R6: edge latched, one entry per edge, unaffected by IF
        flag_if = 0;
        nmi_pin = 1;
        @(negedge clk);
        run_boundary(1, "R6 nmi edge");
        run_boundary(0, "R6 nmi held no retake");
        nmi_pin = 0; @(negedge clk); nmi_pin = 1; @(negedge clk);
        intr_line = 1; flag_if = 1;
        run_boundary(1, "R7 nmi over intr");
        nmi_pin = 0;

        // R7: full priority stack
        req_div = 1; req_ill = 1; req_soft = 1; flag_tf = 1; intr_line = 1;
        run_boundary(0, "R7 div first");
        req_esc = 1; req_int3 = 1; req_into = 1; flag_of = 1; flag_tf = 1;
        run_boundary(0, "R7 esc over int3");
        intr_line = 1; flag_tf = 1; flag_if = 1; intr_type = 8'h0F;
        run_boundary(0, "R7 intr over step");
        flag_tf = 0;

        // R10: requests without a boundary are ignored
        req_div = 1; req_soft = 1;
        @(negedge clk);
        chk(!busy && !take_valid && !stk_we, "R10 no boundary", busy, 0);
        clear_reqs();

        // R10: requests during a running frame are ignored
        req_int3 = 1; boundary = 1;
        @(negedge clk);
        boundary = 1; req_div = 1;
        @(negedge clk);
        chk(stk_we && !take_valid && sel_type == 8'd3, "R10 busy ignored", sel_type, 3);
        clear_reqs();
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !take_valid, "R10 busy no follow-up", busy, 0);

        // R8: stack pointer wrap at zero
        cur_sp = 16'h0002; req_int3 = 1; run_boundary(0, "R8 wrap");

        // R11: returns, including wrap and contention with a boundary
        cur_sp = 16'hFFFC; run_iret(0, "R11 wrap");
        cur_sp = 16'h2000; run_iret(1, "R11 beats boundary");

        // random mix against the priority model
        for (int n = 0; n < 400; n++) begin
            req_div   = ($urandom_range(0, 9) == 0);
            req_ill   = ($urandom_range(0, 9) == 0);
            req_esc   = ($urandom_range(0, 9) == 0);
            req_int3  = ($urandom_range(0, 9) == 0);
            req_into  = ($urandom_range(0, 5) == 0);
            flag_of   = $urandom_range(0, 1);
            req_soft  = ($urandom_range(0, 7) == 0);
            soft_type = 8'($urandom_range(0, 255));
            intr_line = $urandom_range(0, 1);
            intr_type = 8'($urandom_range(0, 255));
            flag_if   = $urandom_range(0, 1);
            flag_tf   = ($urandom_range(0, 3) == 0);
            cur_flags = 16'($urandom);
            cur_cs    = 16'($urandom);
            cur_ip    = 16'($urandom);
            cur_sp    = 16'($urandom);
            if ($urandom_range(0, 9) == 0) run_iret(0, "R11 random");
            else run_boundary(0, "R7 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule